// File: doc/BRIEF.md
# Pipelined burst SRAM cycle controller

This block is a synchronous static RAM with a registered read path and a four-beat burst address sequencer. It is used as a bridge from two bus masters to a local array. A processor-side master starts read bursts with its own address strobe. A memory controller starts read or write bursts with a second strobe. A chip select decides which of the two strobes may act. Every control, address and data input is captured on the rising clock edge. The captured cycle is classified as one of five kinds: no access, deselect, burst start, burst continue or burst suspend. The access itself takes place one edge later, in a command stage. Read data returns through an output register, and the block presents it on the data pads together with a pad drive enable. Driving that enable low is how the block models the high-impedance state.

A burst visits four words inside an aligned group. The first word is the external address. The other three follow an interleaved order that the burst address generator computes. The word is split into byte lanes, and each lane has its own active-low write enable. The block returns the pads to high-impedance at different points for different cycles. After a write cycle this happens at once. After a deselect cycle it happens one edge later, so that a read already in flight can still deliver its data.

Top module: `bsram_core`

## Requirements
- R1: All inputs are captured on the rising clock edge. The data of a read cycle captured at edge k is driven on `dq_o`, with `dq_en` high, after edge k+1, as long as the cycle captured at edge k+1 is not a write.
- R2: With `chip_sel_n` low and `proc_stb_n` low, a read burst starts at `addr`. The cycle is a read whatever value `byte_wr_n` has.
- R3: With `chip_sel_n` low, `proc_stb_n` high and `ctrl_stb_n` low, a burst starts at `addr`. The cycle is a write if any bit of `byte_wr_n` is low, and a read otherwise. Bit 0 of `byte_wr_n` writes `din[8:0]` and bit 1 writes `din[17:9]`. A lane whose bit is high keeps its stored value.
- R4: `chip_sel_n` high blocks `proc_stb_n`. With `chip_sel_n` high, the cycle is a deselect if `ctrl_stb_n` is low, and a continue or suspend if `ctrl_stb_n` is high. The value of `proc_stb_n` does not matter in either case.
- R5: When both strobes are inactive (`ctrl_stb_n` high, and `proc_stb_n` high or blocked), `burst_adv_n` low advances the burst. The two low address bits equal the start address's low bits XOR a beat count. The count goes 1, 2, 3 and then wraps to 0. The upper address bits stay those of the start address.
- R6: Under the same strobe conditions, `burst_adv_n` high repeats the current burst address. The cycle is a read or a write according to `byte_wr_n`.
- R7: A write cycle captured at edge k drives `dq_en` low after edge k, even if a read was captured at edge k-1.
- R8: A deselect cycle captured at edge k lets a read captured at edge k-1 still drive after edge k. It drives `dq_en` low after edge k+1.
- R9: A deselect cycle writes nothing, whatever value `byte_wr_n` has.
- R10: A read cycle captured with `out_en_n` high never drives its data. `dq_en` stays low after the following edge.
- R11: After reset or after a deselect, continue and suspend cycles perform no access, neither read nor write, until a new burst start.
- R12: While `rst_n` is low and after its release, `dq_en` is low and `dq_o` is zero until a read delivers data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| din | input | NUM_LANES*LANE_W | Write data |
| chip_sel_n | input | 1 | Chip select, active low |
| proc_stb_n | input | 1 | Processor-side address strobe, active low, blocked by chip select high |
| ctrl_stb_n | input | 1 | Controller-side address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low; high suspends |
| byte_wr_n | input | NUM_LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Output enable for the read data, active low |
| dq_o | output | NUM_LANES*LANE_W | Read data toward the pads; zero when not driven |
| dq_en | output | 1 | Pad drive enable; low models high-impedance |

## Verification
The bench builds the block with ADDR_W = 6 and keeps the default two lanes of nine bits and the two-bit burst field. A 64-word array can be filled completely by controller write bursts, so every read in the later scenarios compares against known contents. A burst that starts in the top group shows that the wrap stays inside the four aligned words. The bench compares the pad enable and the data after every edge against a reference array and a pipeline model built from the requirements. This comparison covers strobe priority, chip-select gating, the interleaved order, suspend, the lane masks, and the different release points for writes and deselects.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    // Classification of one captured bus cycle
    typedef enum logic [2:0] {
        CYC_IDLE  = 3'd0,   // no access (continue/suspend with no live burst)
        CYC_DESEL = 3'd1,   // chip deselected by the controller strobe
        CYC_START = 3'd2,   // burst begins at the external address
        CYC_CONT  = 3'd3,   // burst advances to the next beat
        CYC_SUSP  = 3'd4    // burst stays on the current beat
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e kind;
        logic      wr;      // access is a write (only set for an access)
    } cyc_cmd_t;

endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
    import bsram_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input  logic                 chip_sel_n,
    input  logic                 proc_stb_n,
    input  logic                 ctrl_stb_n,
    input  logic                 burst_adv_n,
    input  logic [NUM_LANES-1:0] byte_wr_n,
    input  logic                 burst_live,
    output cyc_cmd_t             cmd
);

    logic any_wr;

    always_comb begin
        any_wr = ~&byte_wr_n;
        cmd    = '{kind: CYC_IDLE, wr: 1'b0};
        if (!chip_sel_n && !proc_stb_n) begin
            // processor strobe wins, always a read
            cmd.kind = CYC_START;
            cmd.wr   = 1'b0;
        end else if (!ctrl_stb_n) begin
            if (chip_sel_n) begin
                cmd.kind = CYC_DESEL;
                cmd.wr   = 1'b0;
            end else begin
                cmd.kind = CYC_START;
                cmd.wr   = any_wr;
            end
        end else if (burst_live) begin
            cmd.kind = burst_adv_n ? CYC_SUSP : CYC_CONT;
            cmd.wr   = any_wr;
        end
    end

endmodule

// File: rtl/bsram_burst_gen.sv
module bsram_burst_gen
    import bsram_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_kind_e         kind,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    localparam int HI_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic [HI_W-1:0]    base;
        logic [BURST_W-1:0] lo;
        logic [BURST_W-1:0] cnt;
    } bg_state_t;

    bg_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        cur_addr = {st_q.base, st_q.lo ^ st_q.cnt};
        case (kind)
            CYC_START: begin
                st_d.base = ext_addr[ADDR_W-1:BURST_W];
                st_d.lo   = ext_addr[BURST_W-1:0];
                st_d.cnt  = '0;
                cur_addr  = ext_addr;
            end
            CYC_CONT: begin
                st_d.cnt = st_q.cnt + 1'b1;
                cur_addr = {st_q.base, st_q.lo ^ st_d.cnt};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W    = 8,
    parameter int NUM_LANES = 2,
    parameter int LANE_W    = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr_en,
    input  logic [NUM_LANES-1:0]        wr_lanes,
    input  logic [NUM_LANES*LANE_W-1:0] wr_data,
    input  logic                        rd_en,
    output logic [NUM_LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = NUM_LANES * LANE_W;

    logic [DATA_W-1:0] rd_d, rd_q, mem_word;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) mem[addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign mem_word[g*LANE_W +: LANE_W] = mem[addr];
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) rd_d = mem_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/bsram_core.sv
module bsram_core
    import bsram_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_LANES = 2,
    parameter int LANE_W    = 9,
    parameter int BURST_W   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_LANES*LANE_W-1:0] din,
    input  logic                        chip_sel_n,
    input  logic                        proc_stb_n,
    input  logic                        ctrl_stb_n,
    input  logic                        burst_adv_n,
    input  logic [NUM_LANES-1:0]        byte_wr_n,
    input  logic                        out_en_n,
    output logic [NUM_LANES*LANE_W-1:0] dq_o,
    output logic                        dq_en
);

    localparam int DATA_W = NUM_LANES * LANE_W;

    // Command stage: one captured cycle waiting for its array access
    typedef struct packed {
        logic                 live;   // a burst is open
        logic                 rd;     // command stage holds a read
        logic                 wr;     // command stage holds a write
        logic                 oe;     // output enable captured with the read
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    data;
        logic [NUM_LANES-1:0] lanes;
        logic                 drv;    // pads driven with the output register
    } core_state_t;

    core_state_t       st_d, st_q;
    cyc_cmd_t          cmd;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] rd_data;
    logic              access;

    bsram_decode #(.NUM_LANES(NUM_LANES)) u_decode (
        .chip_sel_n (chip_sel_n),
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .burst_adv_n(burst_adv_n),
        .byte_wr_n  (byte_wr_n),
        .burst_live (st_q.live),
        .cmd        (cmd)
    );

    bsram_burst_gen #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (cmd.kind),
        .ext_addr(addr),
        .cur_addr(cur_addr)
    );

    bsram_array #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (st_q.addr),
        .wr_en   (st_q.wr),
        .wr_lanes(st_q.lanes),
        .wr_data (st_q.data),
        .rd_en   (st_q.rd),
        .rd_data (rd_data)
    );

    always_comb begin
        st_d   = st_q;
        access = (cmd.kind == CYC_START) || (cmd.kind == CYC_CONT) ||
                 (cmd.kind == CYC_SUSP);
        case (cmd.kind)
            CYC_START: st_d.live = 1'b1;
            CYC_DESEL: st_d.live = 1'b0;
            default:   ;
        endcase
        st_d.rd    = access && !cmd.wr;
        st_d.wr    = access && cmd.wr;
        st_d.oe    = !out_en_n;
        st_d.addr  = cur_addr;
        st_d.data  = din;
        st_d.lanes = ~byte_wr_n;
        // a newly captured write releases the pads at once
        st_d.drv   = st_q.rd && st_q.oe && !cmd.wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dq_en = st_q.drv;
    assign dq_o  = st_q.drv ? rd_data : '0;

endmodule

// File: rtl/bsram_core_chk.sv
module bsram_core_chk #(
    parameter int NUM_LANES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 chip_sel_n,
    input logic                 proc_stb_n,
    input logic                 ctrl_stb_n,
    input logic [NUM_LANES-1:0] byte_wr_n,
    input logic                 out_en_n,
    input logic                 dq_en
);

    localparam logic [NUM_LANES-1:0] NO_WR = {NUM_LANES{1'b1}};

    // processor read with write enables low still reads and drives
    assert_proc_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_sel_n && !proc_stb_n && !out_en_n && byte_wr_n != NO_WR) ##1
        (byte_wr_n == NO_WR) |=> dq_en);

    assert_write_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_sel_n && proc_stb_n && !ctrl_stb_n && byte_wr_n != NO_WR) |=> !dq_en);

    assert_desel_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel_n && !ctrl_stb_n) |=> ##1 !dq_en);

    assert_oe_high_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_sel_n && !proc_stb_n && out_en_n) |=> ##1 !dq_en);

    assert_drive_needs_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dq_en |-> !$past(out_en_n, 2));

endmodule

bind bsram_core bsram_core_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_sel_n(chip_sel_n),
    .proc_stb_n(proc_stb_n),
    .ctrl_stb_n(ctrl_stb_n),
    .byte_wr_n (byte_wr_n),
    .out_en_n  (out_en_n),
    .dq_en     (dq_en)
);

// File: tb/bsram_core_test.sv
module bsram_core_test;

    localparam int CLK_P = 10;
    localparam int AW    = 6;
    localparam int DW    = 18;
    localparam int WD    = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          chip_sel_n = 1'b1, proc_stb_n = 1'b1, ctrl_stb_n = 1'b1;
    logic          burst_adv_n = 1'b1, out_en_n = 1'b1;
    logic [1:0]    byte_wr_n = 2'b11;
    logic [DW-1:0] dq_o;
    logic          dq_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bsram_core #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .chip_sel_n(chip_sel_n), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
        .burst_adv_n(burst_adv_n), .byte_wr_n(byte_wr_n), .out_en_n(out_en_n),
        .dq_o(dq_o), .dq_en(dq_en)
    );

    // reference model built from the requirements
    logic [DW-1:0]   ref_mem [0:(1<<AW)-1];
    bit              m_live = 1'b0;
    logic [AW-3:0]   m_base = '0;
    logic [1:0]      m_lo = '0, m_cnt = '0;
    bit              p_rd = 1'b0, p_oe = 1'b0;
    logic [DW-1:0]   p_data = '0;

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 913 + 77);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, capture at posedge, observe at next negedge
    task automatic step(input logic cs, input logic ps, input logic cst, input logic adv,
                        input logic [1:0] we, input logic oe, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string tag);
        int            kind;
        bit            wr;
        bit            any_we;
        bit            exp_en;
        logic [AW-1:0] ea;
        any_we = (we != 2'b11);
        if (!cs && !ps) begin kind = 2; wr = 1'b0; end            // R2
        else if (!cst) begin                                       // R3, R4
            if (cs) begin kind = 1; wr = 1'b0; end
            else    begin kind = 2; wr = any_we; end
        end
        else if (!m_live) begin kind = 0; wr = 1'b0; end           // R11
        else begin kind = adv ? 4 : 3; wr = any_we; end            // R5, R6
        case (kind)
            2: begin m_base = a[AW-1:2]; m_lo = a[1:0]; m_cnt = 2'd0; m_live = 1'b1; end
            1: m_live = 1'b0;
            3: m_cnt = m_cnt + 2'd1;
            default: ;
        endcase
        ea = {m_base, m_lo ^ m_cnt};
        chip_sel_n = cs; proc_stb_n = ps; ctrl_stb_n = cst; burst_adv_n = adv;
        byte_wr_n = we; out_en_n = oe; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
        exp_en = p_rd && p_oe && !wr;                              // R1, R7, R8, R10
        chk(dq_en === exp_en, tag, "dq_en", DW'(dq_en), DW'(exp_en));
        if (exp_en) chk(dq_o === p_data, tag, "dq_o", dq_o, p_data);
        if (kind >= 2) begin
            if (wr) begin
                if (!we[0]) ref_mem[ea][8:0]  = d[8:0];
                if (!we[1]) ref_mem[ea][17:9] = d[17:9];
                p_rd = 1'b0;
            end else begin
                p_rd = 1'b1; p_oe = !oe; p_data = ref_mem[ea];
            end
        end else begin
            p_rd = 1'b0;
        end
    endtask

    task automatic desel(input string tag);
        step(1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, '0, '0, tag);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(dq_en === 1'b0, "R12", "dq_en in reset", DW'(dq_en), '0);
        chk(dq_o === '0, "R12", "dq_o in reset", dq_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dq_en === 1'b0, "R12", "dq_en after reset", DW'(dq_en), '0);
        // R11: no burst open, continue/suspend cycles do nothing
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, '0, '0, "R11");
        step(1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, '0, '0, "R11");
    endtask

    task automatic t_fill;
        for (int g = 0; g < (1 << AW) / 4; g++) begin
            step(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1, AW'(g*4), pat(g*4), "R3");
            for (int b = 1; b < 4; b++)
                step(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, '0, pat(g*4 + b), "R5");
        end
        desel("R8");
    endtask

    task automatic t_proc_burst;
        // R2 write enables ignored; R5 interleaved order 0D,0C,0F,0E then wrap
        step(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 6'h0D, 18'h3FFFF, "R2");
        for (int b = 0; b < 4; b++)
            step(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, '0, '0, "R5");
        // top group wrap stays in the aligned group
        step(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'h3E, '0, "R1");
        for (int b = 0; b < 4; b++)
            step(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, '0, '0, "R5");
        desel("R8");
        desel("R8");
        chk(ref_mem[6'h0D] === pat(6'h0D), "R2", "write enable ignored", ref_mem[6'h0D], pat(6'h0D));
    endtask

    task automatic t_suspend;
        step(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 6'h12, '0, "R3");
        step(1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, '0, '0, "R6");
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, '0, '0, "R5");
        step(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1, '0, 18'h2A5A5, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, '0, '0, "R6");
        step(1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, '0, '0, "R6");
        desel("R8");
    endtask

    task automatic t_lanes;
        step(1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 6'h21, 18'h155AA, "R3");
        step(1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1, 6'h22, 18'h0AB55, "R3");
        step(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'h21, '0, "R3");
        step(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'h22, '0, "R3");
        desel("R3");
        desel("R3");
    endtask

    task automatic t_write_release;
        step(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'h05, '0, "R1");
        step(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 6'h30, 18'h1C3C3, "R7");
        step(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'h30, '0, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, '0, '0, "R1");
        desel("R8");
    endtask

    task automatic t_desel;
        step(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'h09, '0, "R8");
        // deselect with write enables low and the processor strobe low
        step(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 6'h09, 18'h00000, "R9");
        step(1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, '0, '0, "R8");
        // R11: burst closed, a suspend write must not store
        step(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, '0, 18'h3FFFF, "R11");
        step(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'h09, '0, "R9");
        desel("R9");
        chk(ref_mem[6'h09] === pat(6'h09), "R9", "deselect stored nothing", ref_mem[6'h09], pat(6'h09));
    endtask

    task automatic t_oe;
        step(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 6'h17, '0, "R10");
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, '0, '0, "R10");
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b1, '0, '0, "R1");
        step(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, '0, '0, "R10");
        desel("R10");
    endtask

    task automatic t_gate;
        step(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'h28, '0, "R2");
        // chip select high blocks the processor strobe: continue instead
        step(1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, 6'h00, '0, "R4");
        step(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'h00, '0, "R4");
        step(1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, 6'h00, '0, "R4");
        step(1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 6'h00, '0, "R4");
        step(1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, '0, '0, "R4");
        desel("R8");
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
        t_reset();
        t_fill();
        t_proc_burst();
        t_suspend();
        t_lanes();
        t_write_release();
        t_desel();
        t_oe();
        t_gate();
        done = 1'b1;
        finish_run();
    end

endmodule